// File: doc/BRIEF.md
# Dual-Modulus PLL Feedback Divider

This block divides the oscillator clock of an integer-N synthesizer down to the comparison rate of the phase-frequency detector. A prescaler counts either P or P+1 oscillator cycles per sub-period. A swallow counter (A) and a period counter (B) run on the prescaler terminal count. For the first A sub-periods of every output period the prescaler uses P+1, and for the rest it uses P. This gives N = P·B + A oscillator cycles per feedback pulse.

The prescaler base P is chosen by a two-bit mode input: P = 2 << mode, so P is 2, 4, 8 or 16. The divider keeps its own copy of the active setting and takes new inputs only at a period boundary or during a synchronous counter reset. A setting with A > B, or with B = 0, is rejected and flagged. A bypass control reduces the divider to the prescaler alone. The active ratio is always visible on a status output.

Top module: `dmd_fb_divider`

## Requirements
- R1: With bypass off, the feedback output pulses once every N = P·B + A input clock cycles, where P = 2 << pmode_i (2, 4, 8, 16 for pmode_i = 0..3).
- R2: With pmode_i = 0 (P = 2), A = 2 and B = 7, the feedback period is 16 cycles.
- R3: The swallow count may range from A = 0 (every sub-period divides by P) up to A = B (every sub-period divides by P+1), and the period follows R1 at both ends.
- R4: With bypass on, the period is P cycles whatever A and B hold, and n_value_o reports P.
- R5: cfg_invalid_o is 1 exactly when bypass is off and either A > B or B = 0. Such a setting is never accepted: the active ratio and n_value_o keep their previous value, even through a counter reset.
- R6: fb_pulse_o is high for exactly one input clock cycle per period.
- R7: While cnt_reset_i is high, no pulse is issued and the current valid inputs become the active setting. The first pulse follows N clock edges after the last edge on which cnt_reset_i was high.
- R8: Input changes without a counter reset take effect only at the next terminal count. The period in progress completes with the old ratio, and n_value_o changes only at that boundary.
- R9: After asynchronous reset, fb_pulse_o is 0 and the active setting is P = 2, A = 0, B = 1 with bypass off (n_value_o = 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator (input) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pmode_i | input | 2 | Prescaler mode, P = 2 << pmode_i |
| a_val_i | input | 6 | Swallow count A |
| b_val_i | input | 13 | Period count B |
| b_bypass_i | input | 1 | Bypass the A/B counters, output = prescaler |
| cnt_reset_i | input | 1 | Synchronous counter reset and setting load |
| fb_pulse_o | output | 1 | One-cycle feedback pulse to the detector |
| n_value_o | output | 18 | Active division ratio |
| cfg_invalid_o | output | 1 | Current inputs form an unusable setting |

## Verification
The hardest case to reach is a setting change that arrives while a period is already running. The change must not disturb that period, yet it must be in force for the next one. To reach it, the stimulus waits for a feedback pulse and then changes the inputs on the next half cycle, without asserting the counter reset. It then measures two consecutive pulse spacings: the first must equal the old ratio and the second the new one. Rejected settings are handled the same way: a setting with A > B is presented and a counter reset is forced. The measured period and n_value_o must still show the previous ratio.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  parameter int unsigned A_W  = 6;
  parameter int unsigned B_W  = 13;
  parameter int unsigned PM_W = 2;

  localparam int unsigned P_MAX = 2 << ((1 << PM_W) - 1);
  localparam int unsigned PC_W  = $clog2(P_MAX + 2);
  localparam int unsigned N_W   = B_W + $clog2(P_MAX) + 1;

  typedef struct packed {
    logic [PM_W-1:0] pm;
    logic [A_W-1:0]  a;
    logic [B_W-1:0]  b;
    logic            byp;
  } dmd_cfg_t;

  localparam dmd_cfg_t CFG_RST = '{pm: '0, a: '0, b: B_W'(1), byp: 1'b0};

  function automatic logic [PC_W-1:0] p_of(logic [PM_W-1:0] pm);
    return PC_W'(2) << pm;
  endfunction

  function automatic logic cfg_ok(dmd_cfg_t c);
    return c.byp || ((c.b != '0) && (B_W'(c.a) <= c.b));
  endfunction
endpackage

// File: rtl/dmd_cfg_reg.sv
module dmd_cfg_reg
  import dmd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  dmd_cfg_t       cfg_in_i,
  output dmd_cfg_t       cfg_o,
  output dmd_cfg_t       cfg_next_o,
  output logic           invalid_o,
  output logic [N_W-1:0] n_o
);
  dmd_cfg_t        act_q;
  logic            in_ok;
  logic [PC_W-1:0] p_act;

  assign in_ok      = cfg_ok(cfg_in_i);
  assign invalid_o  = ~in_ok;
  assign cfg_next_o = in_ok ? cfg_in_i : act_q;
  assign cfg_o      = act_q;
  assign p_act      = p_of(act_q.pm);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= CFG_RST;
    else if (load_i) act_q <= cfg_next_o;
  end

  always_comb begin
    if (act_q.byp) n_o = N_W'(p_act);
    else           n_o = N_W'(p_act) * N_W'(act_q.b) + N_W'(act_q.a);
  end

  // rejected input must leave the active ratio alone
  AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !in_ok) |=> $stable(n_o)); // R5
endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler
  import dmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PC_W-1:0] p_i,
  input  logic            swallow_i,
  output logic            tc_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mod;

  assign mod  = p_i + PC_W'(swallow_i);
  assign tc_o = (pc_q == mod - PC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pc_q <= '0;
    else if (clr_i || tc_o)  pc_q <= '0;
    else                     pc_q <= pc_q + PC_W'(1);
  end

  AST_PC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q < mod); // R1
endmodule

// File: rtl/dmd_ab_ctr.sv
module dmd_ab_ctr
  import dmd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           pre_tc_i,
  input  logic           byp_i,
  input  logic [A_W-1:0] a_nxt_i,
  input  logic [B_W-1:0] b_nxt_i,
  output logic           swallow_o,
  output logic           term_o
);
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;

  assign swallow_o = ~byp_i && (a_q != '0);
  assign term_o    = pre_tc_i && (byp_i || (b_q == B_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= CFG_RST.a;
      b_q <= CFG_RST.b;
    end else if (restart_i || term_o) begin
      a_q <= a_nxt_i;
      b_q <= b_nxt_i;
    end else if (pre_tc_i) begin
      b_q <= b_q - B_W'(1);
      if (a_q != '0) a_q <= a_q - A_W'(1);
    end
  end

  AST_A_WITHIN_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_i |-> (B_W'(a_q) <= b_q)); // R3
  AST_B_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_i |-> (b_q != '0)); // R1
endmodule

// File: rtl/dmd_fb_divider.sv
module dmd_fb_divider
  import dmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PM_W-1:0] pmode_i,
  input  logic [A_W-1:0]  a_val_i,
  input  logic [B_W-1:0]  b_val_i,
  input  logic            b_bypass_i,
  input  logic            cnt_reset_i,
  output logic            fb_pulse_o,
  output logic [N_W-1:0]  n_value_o,
  output logic            cfg_invalid_o
);
  dmd_cfg_t cfg_in, cfg_act, cfg_nxt;
  logic     pre_tc, term, swallow, load;

  assign cfg_in = '{pm: pmode_i, a: a_val_i, b: b_val_i, byp: b_bypass_i};
  assign load   = cnt_reset_i || term;

  dmd_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .cfg_in_i   (cfg_in),
    .cfg_o      (cfg_act),
    .cfg_next_o (cfg_nxt),
    .invalid_o  (cfg_invalid_o),
    .n_o        (n_value_o)
  );

  dmd_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load),
    .p_i       (p_of(cfg_act.pm)),
    .swallow_i (swallow),
    .tc_o      (pre_tc)
  );

  dmd_ab_ctr u_ab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cnt_reset_i),
    .pre_tc_i  (pre_tc),
    .byp_i     (cfg_act.byp),
    .a_nxt_i   (cfg_nxt.a),
    .b_nxt_i   (cfg_nxt.b),
    .swallow_o (swallow),
    .term_o    (term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_pulse_o <= 1'b0;
    else         fb_pulse_o <= term && !cnt_reset_i;
  end

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o); // R6
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_reset_i |=> !fb_pulse_o); // R7
  AST_NVAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(n_value_o)); // R8
endmodule

// File: tb/tb_dmd_fb_divider.sv
module tb_dmd_fb_divider;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  pmode = '0;
  logic [5:0]  a_val = '0;
  logic [12:0] b_val = '0;
  logic        byp = 1'b0;
  logic        crst = 1'b0;
  logic        fb;
  logic [17:0] nval;
  logic        inval;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dmd_fb_divider dut (
    .clk_i(clk), .rst_ni(rst_ni), .pmode_i(pmode), .a_val_i(a_val),
    .b_val_i(b_val), .b_bypass_i(byp), .cnt_reset_i(crst),
    .fb_pulse_o(fb), .n_value_o(nval), .cfg_invalid_o(inval)
  );

  // pm, a, b, bypass, expected N
  localparam int VEC[8][5] = '{
    '{0,  2, 7, 0, 16},
    '{1,  0, 3, 0, 12},
    '{1,  4, 4, 0, 20},
    '{2,  5, 9, 0, 77},
    '{3,  1, 1, 0, 17},
    '{0,  0, 1, 0,  2},
    '{2,  3, 5, 1,  8},
    '{3, 40, 2, 1, 16}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int pm, input int a, input int b, input int bp);
    pmode = 2'(pm); a_val = 6'(a); b_val = 13'(b); byp = bp[0];
  endtask

  // pulse counter reset, return edges until first pulse
  task automatic restart_latency(output int k);
    crst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    crst = 1'b0;
    k = 0;
    do begin
      @(posedge clk); k++;
      @(negedge clk);
    end while (!fb && k < 1000);
  endtask

  // called at a negedge where fb is high
  task automatic spacing(output int j);
    j = 0;
    do begin
      @(negedge clk); j++;
    end while (!fb && j < 1000);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int k, j;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R9 reset state
    chk(fb == 1'b0, "R9 fb after reset", int'(fb), 0);
    chk(nval == 18'd2, "R9 n_value after reset", int'(nval), 2);
    // zero inputs mean B=0: flagged, not taken (R5)
    chk(inval == 1'b1, "R5 B=0 flagged", int'(inval), 1);
    restart_latency(k);
    chk(k == 2, "R5 B=0 rejected keeps N=2", k, 2);

    foreach (VEC[i]) begin
      set_cfg(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      @(negedge clk);
      chk(inval == 1'b0, "R5 valid not flagged", int'(inval), 0);
      restart_latency(k);
      chk(k == VEC[i][4], "R7 first pulse latency", k, VEC[i][4]);
      chk(int'(nval) == VEC[i][4], VEC[i][3] ? "R4 n_value bypass" : "R1 n_value", int'(nval), VEC[i][4]);
      spacing(j);
      chk(j == VEC[i][4], i == 0 ? "R2 period 2/3 A2 B7" : (VEC[i][3] ? "R4 bypass period" : "R1 R3 period"), j, VEC[i][4]);
      @(negedge clk);
      chk(fb == 1'b0, "R6 pulse one cycle", int'(fb), 0);
    end

    // invalid A>B rejected through counter reset (R5)
    set_cfg(0, 2, 7, 0);
    restart_latency(k);
    set_cfg(0, 5, 3, 0);
    @(negedge clk);
    chk(inval == 1'b1, "R5 A>B flagged", int'(inval), 1);
    restart_latency(k);
    chk(k == 16, "R5 A>B rejected latency", k, 16);
    chk(nval == 18'd16, "R5 A>B n_value kept", int'(nval), 16);

    // hold counter reset: no pulses (R7)
    crst = 1'b1;
    begin
      int seen = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (fb) seen++;
      end
      chk(seen == 0, "R7 no pulse under reset", seen, 0);
    end
    set_cfg(0, 2, 7, 0);
    @(negedge clk);
    crst = 1'b0;

    // change mid-period (R8)
    do @(negedge clk); while (!fb);
    set_cfg(1, 0, 3, 0);
    chk(nval == 18'd16, "R8 n_value before boundary", int'(nval), 16);
    spacing(j);
    chk(j == 16, "R8 running period unchanged", j, 16);
    spacing(j);
    chk(j == 12, "R8 new period after boundary", j, 12);
    chk(nval == 18'd12, "R8 n_value after boundary", int'(nval), 12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule